// File: doc/BRIEF.md
# Charger Command Slave

This block is the serial management front end of a battery charger. It listens on a two-wire SMBus segment as a slave with one fixed address, accepts word writes that program a charge-current setpoint and a charge-voltage setpoint, and answers word reads that return either setpoint or a status word. The status word carries the monitored charger inputs (battery present, adapter present and similar) and two overrange flags, one per setpoint. A flag is raised when the most recent value written to its setpoint reaches a configured limit.

The block watches its status inputs on every clock. When any of them changes, it pulls an active-low alert line so that the host does not need to poll. The host finds the source of the alert by reading the Alert Response Address. The block answers that read with its own address byte and then lets the alert line go.

The bus lines arrive as plain inputs and are sampled by a faster system clock. SDA is driven back as an open-drain enable. SCL is input only, because the block never stretches the clock. The block has no dependency on the charger's power input, so it keeps answering the bus, including status reads, whether or not an adapter is present. Each accepted setpoint write also produces a one-cycle pulse for the downstream charge controller.

Top module: `chg_smb_slave`

## Requirements
- R1: The block acknowledges only the address byte 0x12 (7-bit address 0x09, write direction). For any other address byte it leaves SDA released for the whole transaction, and no setpoint or flag changes.
- R2: Write word with command 0x14, low byte first, loads the charge-current setpoint with data bits [9:0]. In the cycle the new value appears, the block pulses cur_wr_pulse for one cycle.
- R3: Write word with command 0x15, low byte first, loads the charge-voltage setpoint with data bits [10:0]. In the cycle the new value appears, the block pulses volt_wr_pulse for one cycle.
- R4: A read word is formed as the command byte, then a repeated start, then the byte 0x13 (own address, read direction). The block returns the low byte first, and the master ACKs that byte and NACKs the high byte. Command 0x13 returns the status word: bits [3:0] hold status_in, bit 14 is the current overrange flag, bit 15 is the voltage overrange flag, and all other bits are 0. Commands 0x14 and 0x15 return their setpoint, zero-extended.
- R5: Each overrange flag follows the latest write to its setpoint. The flag is set when the whole 16-bit data word is greater than or equal to that setpoint's limit (defaults 0x0300 for current, 0x0600 for voltage), and cleared when the word is below the limit.
- R6: Any change on status_in drives alert_n low. alert_n stays low through status reads.
- R7: The block acknowledges the byte 0x19 (Alert Response Address 0x0C, read direction) only while the alert is pending. It then sends 0x12 and releases alert_n at the end of that byte. While no alert is pending, 0x19 is NACKed.
- R8: A Stop at any point returns the interface to idle. A write cut off by a Stop changes no setpoint and produces no pulse. A Stop also forgets the last command byte, so a read address that follows a fresh Start is NACKed.
- R9: The block NACKs a command byte other than 0x13, 0x14 or 0x15. A write word to 0x13 is NACKed at its first data byte.
- R10: After reset, both setpoints are 0, alert_n is high and SDA is released.
- R11: The block samples bus data on a rising edge of SCL and changes its SDA drive only after a falling edge of SCL. The drive is never altered while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| status_in | input | NSTAT (4) | Monitored charger status inputs |
| cur_setpoint | output | CUR_W (10) | Charge-current setpoint |
| volt_setpoint | output | VOLT_W (11) | Charge-voltage setpoint |
| cur_wr_pulse | output | 1 | One-cycle pulse on an accepted current write |
| volt_wr_pulse | output | 1 | One-cycle pulse on an accepted voltage write |
| alert_n | output | 1 | Active-low alert, raised on a status change |

## Verification
The hardest state to reach from the ports is the alert handshake. The Alert Response Address is acknowledged only while an alert is pending, and that alert can only come from a change on the status inputs between bus transactions. The bench therefore first changes status_in while the bus is idle. It then shows that a status read leaves the alert in place, runs the alert-response read and checks the returned address and the released line, and finally repeats the same read to see it NACKed. Stops are also injected after the low data byte and between the command and the read address, to confirm that a cut-off transaction leaves nothing behind.

// File: rtl/chg_smb_pkg.sv
package chg_smb_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WLO,
        ST_WHI,
        ST_RLO,
        ST_RHI,
        ST_ARA,
        ST_SKIP
    } smb_state_e;

    // Bus events derived from the synchronized lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Completed write-word request
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] cmd;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [6:0] a7, input logic rd);
        return {a7, rd};
    endfunction

    function automatic logic is_tx_state(input smb_state_e s);
        return (s == ST_RLO) || (s == ST_RHI) || (s == ST_ARA);
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import chg_smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // index 1 = SCL, index 0 = SDA
    always_comb begin
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] & ~prev[1];
        ev.scl_fall = ~synced[1] & prev[1];
        ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
    import chg_smb_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR   = 7'h09,
    parameter logic [6:0] ARA_ADDR   = 7'h0C,
    parameter logic [7:0] CMD_STATUS = 8'h13,
    parameter logic [7:0] CMD_CUR    = 8'h14,
    parameter logic [7:0] CMD_VOLT   = 8'h15
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_ev_t             ev,
    input  logic                alert_active,
    input  logic [WORD_W-1:0]   rd_data,
    output logic [BYTE_W-1:0]   rd_cmd,
    output logic                sda_oe,
    output wr_req_t             wr_req,
    output logic                ara_done
);
    localparam logic [BYTE_W-1:0] A_WR  = addr_byte(OWN_ADDR, 1'b0);
    localparam logic [BYTE_W-1:0] A_RD  = addr_byte(OWN_ADDR, 1'b1);
    localparam logic [BYTE_W-1:0] A_ARA = addr_byte(ARA_ADDR, 1'b1);
    localparam logic [3:0]        ACK_SLOT = 4'd8;
    localparam logic [3:0]        END_SLOT = 4'd9;

    smb_state_e        state, pend, ack_pend, nxt_st;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, lo_q, cmd_q, nxt_byte;
    logic [WORD_W-1:0] rd_word;
    logic              cmd_ok, mack_n, tx, ack_now;

    assign tx     = is_tx_state(state);
    assign rd_cmd = cmd_q;

    // Acknowledge decision for a received byte
    always_comb begin
        ack_now  = 1'b0;
        ack_pend = ST_SKIP;
        case (state)
            ST_ADDR: begin
                if (shreg == A_WR) begin
                    ack_now = 1'b1; ack_pend = ST_CMD;
                end else if (shreg == A_RD && cmd_ok) begin
                    ack_now = 1'b1; ack_pend = ST_RLO;
                end else if (shreg == A_ARA && alert_active) begin
                    ack_now = 1'b1; ack_pend = ST_ARA;
                end
            end
            ST_CMD: begin
                if (shreg == CMD_STATUS || shreg == CMD_CUR || shreg == CMD_VOLT) begin
                    ack_now = 1'b1; ack_pend = ST_WLO;
                end
            end
            ST_WLO: begin
                if (cmd_q != CMD_STATUS) begin
                    ack_now = 1'b1; ack_pend = ST_WHI;
                end
            end
            ST_WHI: begin
                ack_now = 1'b1; ack_pend = ST_SKIP;
            end
            default: ;
        endcase
    end

    // Next state and byte to load at the end of a frame
    always_comb begin
        nxt_st = pend;
        if (tx) nxt_st = (state == ST_RLO && !mack_n) ? ST_RHI : ST_SKIP;
        case (nxt_st)
            ST_RLO:  nxt_byte = rd_word[7:0];
            ST_RHI:  nxt_byte = rd_word[15:8];
            ST_ARA:  nxt_byte = A_WR;
            default: nxt_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        wr_req.valid <= 1'b0;
        ara_done     <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= ST_SKIP;
            bitcnt  <= '0;
            shreg   <= '0;
            lo_q    <= '0;
            cmd_q   <= '0;
            rd_word <= '0;
            cmd_ok  <= 1'b0;
            mack_n  <= 1'b1;
            sda_oe  <= 1'b0;
            wr_req  <= '0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            cmd_ok <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (ev.scl_rise) begin
                if (!tx && bitcnt < ACK_SLOT) shreg <= {shreg[6:0], ev.sda};
                if (tx && bitcnt == ACK_SLOT) mack_n <= ev.sda;
                if (bitcnt != END_SLOT) bitcnt <= bitcnt + 4'd1;
            end else if (ev.scl_fall) begin
                if (bitcnt == ACK_SLOT) begin
                    if (tx) begin
                        sda_oe <= 1'b0;
                    end else begin
                        sda_oe <= ack_now;
                        pend   <= ack_pend;
                        if (ack_now) begin
                            case (state)
                                ST_ADDR: rd_word <= rd_data;
                                ST_CMD: begin
                                    cmd_q  <= shreg;
                                    cmd_ok <= 1'b1;
                                end
                                ST_WLO: lo_q <= shreg;
                                ST_WHI: begin
                                    wr_req.valid <= 1'b1;
                                    wr_req.cmd   <= cmd_q;
                                    wr_req.data  <= {shreg, lo_q};
                                end
                                default: ;
                            endcase
                        end
                    end
                end else if (bitcnt == END_SLOT) begin
                    bitcnt <= '0;
                    state  <= nxt_st;
                    shreg  <= nxt_byte;
                    sda_oe <= is_tx_state(nxt_st) & ~nxt_byte[7];
                    if (state == ST_ARA) ara_done <= 1'b1;
                end else if (tx && bitcnt != 4'd0) begin
                    shreg  <= {shreg[6:0], 1'b0};
                    sda_oe <= ~shreg[6];
                end
            end
        end
    end

endmodule

// File: rtl/chg_setpoint_chan.sv
module chg_setpoint_chan
    import chg_smb_pkg::*;
#(
    parameter int                W     = 10,
    parameter logic [WORD_W-1:0] LIMIT = 16'h0300,
    parameter logic [BYTE_W-1:0] CMD   = 8'h14
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr_req,
    output logic [W-1:0]  value,
    output logic          pulse,
    output logic          over
);
    logic hit;
    assign hit = wr_req.valid && (wr_req.cmd == CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            pulse <= 1'b0;
            over  <= 1'b0;
        end else begin
            pulse <= hit;
            if (hit) begin
                value <= wr_req.data[W-1:0];
                over  <= (wr_req.data >= LIMIT);
            end
        end
    end

endmodule

// File: rtl/chg_alert_mon.sv
module chg_alert_mon #(
    parameter int NSTAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] status_in,
    input  logic             ara_done,
    output logic [NSTAT-1:0] stat_q,
    output logic             alert_active
);
    always_ff @(posedge clk) begin
        stat_q <= status_in;
        if (rst) begin
            alert_active <= 1'b0;
        end else if (status_in != stat_q) begin
            alert_active <= 1'b1;
        end else if (ara_done) begin
            alert_active <= 1'b0;
        end
    end

endmodule

// File: rtl/chg_smb_slave.sv
module chg_smb_slave
    import chg_smb_pkg::*;
#(
    parameter logic [6:0]        OWN_ADDR   = 7'h09,
    parameter logic [6:0]        ARA_ADDR   = 7'h0C,
    parameter logic [7:0]        CMD_STATUS = 8'h13,
    parameter logic [7:0]        CMD_CUR    = 8'h14,
    parameter logic [7:0]        CMD_VOLT   = 8'h15,
    parameter int                CUR_W      = 10,
    parameter int                VOLT_W     = 11,
    parameter logic [15:0]       CUR_LIMIT  = 16'h0300,
    parameter logic [15:0]       VOLT_LIMIT = 16'h0600,
    parameter int                NSTAT      = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [NSTAT-1:0]  status_in,
    output logic [CUR_W-1:0]  cur_setpoint,
    output logic [VOLT_W-1:0] volt_setpoint,
    output logic              cur_wr_pulse,
    output logic              volt_wr_pulse,
    output logic              alert_n
);
    localparam int PAD_W = WORD_W - 2 - NSTAT;

    bus_ev_t           ev;
    wr_req_t           wr_req;
    logic              alert_active, ara_done, ov_cur, ov_volt;
    logic [BYTE_W-1:0] rd_cmd;
    logic [WORD_W-1:0] rd_data, status_word;
    logic [NSTAT-1:0]  stat_q;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    smb_byte_engine #(
        .OWN_ADDR(OWN_ADDR), .ARA_ADDR(ARA_ADDR),
        .CMD_STATUS(CMD_STATUS), .CMD_CUR(CMD_CUR), .CMD_VOLT(CMD_VOLT)
    ) u_engine (
        .clk(clk), .rst(rst), .ev(ev), .alert_active(alert_active),
        .rd_data(rd_data), .rd_cmd(rd_cmd), .sda_oe(sda_oe),
        .wr_req(wr_req), .ara_done(ara_done)
    );

    chg_setpoint_chan #(.W(CUR_W), .LIMIT(CUR_LIMIT), .CMD(CMD_CUR)) u_cur (
        .clk(clk), .rst(rst), .wr_req(wr_req),
        .value(cur_setpoint), .pulse(cur_wr_pulse), .over(ov_cur)
    );

    chg_setpoint_chan #(.W(VOLT_W), .LIMIT(VOLT_LIMIT), .CMD(CMD_VOLT)) u_volt (
        .clk(clk), .rst(rst), .wr_req(wr_req),
        .value(volt_setpoint), .pulse(volt_wr_pulse), .over(ov_volt)
    );

    chg_alert_mon #(.NSTAT(NSTAT)) u_alert (
        .clk(clk), .rst(rst), .status_in(status_in), .ara_done(ara_done),
        .stat_q(stat_q), .alert_active(alert_active)
    );

    assign status_word = {ov_volt, ov_cur, {PAD_W{1'b0}}, stat_q};
    assign alert_n     = ~alert_active;

    always_comb begin
        if (rd_cmd == CMD_CUR)       rd_data = {{(WORD_W-CUR_W){1'b0}}, cur_setpoint};
        else if (rd_cmd == CMD_VOLT) rd_data = {{(WORD_W-VOLT_W){1'b0}}, volt_setpoint};
        else                         rd_data = status_word;
    end

endmodule

// File: rtl/chg_smb_checker.sv
module chg_smb_checker #(
    parameter int CUR_W  = 10,
    parameter int VOLT_W = 11,
    parameter int NSTAT  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [NSTAT-1:0]  status_in,
    input logic [CUR_W-1:0]  cur_setpoint,
    input logic [VOLT_W-1:0] volt_setpoint,
    input logic              cur_wr_pulse,
    input logic              volt_wr_pulse,
    input logic              ov_cur,
    input logic              ov_volt,
    input logic              ara_done,
    input logic              alert_n
);
    // R11: drive held while SCL has been high for several samples
    a_r11_sda_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));

    // R2: current setpoint moves only together with its pulse
    a_r2_cur_changes_with_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_setpoint) |-> cur_wr_pulse);

    // R3: voltage setpoint moves only together with its pulse
    a_r3_volt_changes_with_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(volt_setpoint) |-> volt_wr_pulse);

    // R5: overrange flags change only on a write to their setpoint
    a_r5_ov_cur_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ov_cur) |-> cur_wr_pulse);
    a_r5_ov_volt_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ov_volt) |-> volt_wr_pulse);

    // R6: alert is raised only after a status input changed
    a_r6_alert_from_change: assert property (@(posedge clk) disable iff (rst)
        $fell(alert_n) |-> ($past(status_in) != $past(status_in, 2)));

    // R7: alert is released only by a finished alert-response byte
    a_r7_release_by_ara: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_n) |-> $past(ara_done));

    // R2/R3 strobes never coincide
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cur_wr_pulse, volt_wr_pulse}));

endmodule

bind chg_smb_slave chg_smb_checker #(
    .CUR_W(CUR_W), .VOLT_W(VOLT_W), .NSTAT(NSTAT)
) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .status_in(status_in), .cur_setpoint(cur_setpoint),
    .volt_setpoint(volt_setpoint), .cur_wr_pulse(cur_wr_pulse),
    .volt_wr_pulse(volt_wr_pulse), .ov_cur(ov_cur), .ov_volt(ov_volt),
    .ara_done(ara_done), .alert_n(alert_n)
);

// File: tb/tb_chg_smb_slave.sv
module tb_chg_smb_slave;
    localparam int Q = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst   = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic [3:0]  stat  = 4'b0101;
    logic        sda_oe, cur_wr_pulse, volt_wr_pulse, alert_n;
    logic [9:0]  cur;
    logic [10:0] volt;
    wire         sda_line = ~(m_low | sda_oe);

    chg_smb_slave dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .status_in(stat), .cur_setpoint(cur), .volt_setpoint(volt),
        .cur_wr_pulse(cur_wr_pulse), .volt_wr_pulse(volt_wr_pulse), .alert_n(alert_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct { bit is_volt; int val; } exp_t;
    exp_t sb[$];

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected setpoint writes as pulses appear
    always @(negedge clk) begin
        exp_t e;
        if (!rst && (cur_wr_pulse || volt_wr_pulse)) begin
            if (sb.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R8 unexpected write pulse actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                chk("R2 R3 pulse kind", int'(volt_wr_pulse), int'(e.is_volt));
                chk("R2 R3 pulse value", e.is_volt ? int'(volt) : int'(cur), e.val);
            end
        end
    end

    task automatic bus_start();
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        m_scl = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            m_scl = 1'b1;  wq(Q);
            m_scl = 1'b0;  wq(2);
        end
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(2);
        ack = (sda_line == 1'b0);
        wq(Q - 2);
        m_scl = 1'b0; wq(2);
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            m_scl = 1'b1; wq(2);
            b[i] = sda_line;
            wq(Q - 2);
            m_scl = 1'b0; wq(2);
        end
        m_low = ~nack; wq(Q);
        m_scl = 1'b1;  wq(Q);
        m_scl = 1'b0;  wq(2);
        m_low = 1'b0;
    endtask

    // Returns the four ACK bits {addr, cmd, lo, hi}
    task automatic write_word(input logic [7:0] addr, input logic [7:0] cmd,
                              input logic [15:0] data, output logic [3:0] acks);
        bit a;
        exp_t e;
        acks = 4'b0000;
        if (addr == 8'h12 && (cmd == 8'h14 || cmd == 8'h15)) begin
            e.is_volt = (cmd == 8'h15);
            e.val = (cmd == 8'h15) ? int'(data[10:0]) : int'(data[9:0]);
            sb.push_back(e);
        end
        bus_start();
        write_byte(addr, a); acks[3] = a;
        if (a) begin write_byte(cmd, a); acks[2] = a; end
        if (acks[2]) begin write_byte(data[7:0], a); acks[1] = a; end
        if (acks[1]) begin write_byte(data[15:8], a); acks[0] = a; end
        bus_stop();
        wq(4);
    endtask

    task automatic read_word(input logic [7:0] cmd, output logic [15:0] data, output bit ok);
        bit a1, a2, a3;
        logic [7:0] lo, hi;
        bus_start();
        write_byte(8'h12, a1);
        write_byte(cmd, a2);
        bus_start();
        write_byte(8'h13, a3);
        read_byte(1'b0, lo);
        read_byte(1'b1, hi);
        bus_stop();
        data = {hi, lo};
        ok = a1 & a2 & a3;
        wq(4);
    endtask

    task automatic ara_read(output bit ack, output logic [7:0] b);
        bus_start();
        write_byte(8'h19, ack);
        b = 8'hFF;
        if (ack) read_byte(1'b1, b);
        bus_stop();
        wq(4);
    endtask

    initial begin
        logic [3:0]  acks;
        logic [15:0] rd;
        logic [7:0]  b;
        bit ok, a;

        wq(6);
        rst = 1'b0;
        wq(4);

        // R10 reset state
        chk("R10 cur after reset", int'(cur), 0);
        chk("R10 volt after reset", int'(volt), 0);
        chk("R10 alert_n after reset", int'(alert_n), 1);
        chk("R10 sda released", int'(sda_oe), 0);

        // R4 status read from reset
        read_word(8'h13, rd, ok);
        chk("R4 status read acks", int'(ok), 1);
        chk("R4 R11 status word", int'(rd), 16'h0005);

        // R2 current write and readback
        write_word(8'h12, 8'h14, 16'h0123, acks);
        chk("R2 write acks", int'(acks), 4'hF);
        chk("R2 current setpoint", int'(cur), 10'h123);
        read_word(8'h14, rd, ok);
        chk("R4 R11 current readback", int'(rd), 16'h0123);

        // R3 voltage write
        write_word(8'h12, 8'h15, 16'h0456, acks);
        chk("R3 write acks", int'(acks), 4'hF);
        chk("R3 voltage setpoint", int'(volt), 11'h456);
        read_word(8'h15, rd, ok);
        chk("R4 voltage readback", int'(rd), 16'h0456);

        // R5 overrange at and around the limits
        write_word(8'h12, 8'h14, 16'h0300, acks);
        read_word(8'h13, rd, ok);
        chk("R5 current at limit flags", int'(rd), 16'h4005);
        write_word(8'h12, 8'h14, 16'h02FF, acks);
        read_word(8'h13, rd, ok);
        chk("R5 current below limit clears", int'(rd), 16'h0005);
        chk("R2 current 0x2FF", int'(cur), 10'h2FF);
        write_word(8'h12, 8'h15, 16'hFFFF, acks);
        chk("R3 voltage truncated", int'(volt), 11'h7FF);
        read_word(8'h13, rd, ok);
        chk("R5 voltage over flags", int'(rd), 16'h8005);
        write_word(8'h12, 8'h15, 16'h05FF, acks);
        read_word(8'h13, rd, ok);
        chk("R5 voltage below clears", int'(rd), 16'h0005);

        // R1 foreign address
        write_word(8'h16, 8'h14, 16'h0001, acks);
        chk("R1 foreign address nacked", int'(acks), 0);
        chk("R1 current untouched", int'(cur), 10'h2FF);

        // R9 unknown command and status write
        write_word(8'h12, 8'h20, 16'h0001, acks);
        chk("R9 unknown command nack", int'(acks), 4'b1000);
        write_word(8'h12, 8'h13, 16'h0001, acks);
        chk("R9 status write nack at data", int'(acks), 4'b1100);

        // R8 stop after low byte
        bus_start();
        write_byte(8'h12, a);
        write_byte(8'h14, a);
        write_byte(8'h55, a);
        bus_stop();
        wq(4);
        chk("R8 aborted write keeps current", int'(cur), 10'h2FF);
        // R8 stop forgets command: read address after fresh start
        bus_start();
        write_byte(8'h12, a);
        write_byte(8'h13, a);
        bus_stop();
        bus_start();
        write_byte(8'h13, a);
        bus_stop();
        wq(4);
        chk("R8 read after stop nacked", int'(a), 0);

        // R7 no alert pending: ARA nacked
        ara_read(a, b);
        chk("R7 ARA nack without alert", int'(a), 0);

        // R6 status change raises alert
        stat = 4'b0111;
        wq(5);
        chk("R6 alert on change", int'(alert_n), 0);
        read_word(8'h13, rd, ok);
        chk("R6 status word new inputs", int'(rd), 16'h0007);
        chk("R6 alert held after status read", int'(alert_n), 0);

        // R7 alert response
        ara_read(a, b);
        chk("R7 ARA acked", int'(a), 1);
        chk("R7 ARA returns own address", int'(b), 8'h12);
        chk("R7 alert released", int'(alert_n), 1);
        ara_read(a, b);
        chk("R7 second ARA nacked", int'(a), 0);

        // R6 second change, then clear
        stat = 4'b0001;
        wq(5);
        chk("R6 alert on second change", int'(alert_n), 0);
        ara_read(a, b);
        chk("R7 second alert released", int'(alert_n), 1);

        wq(10);
        chk("R2 R3 all expected pulses seen", sb.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule